// File: doc/BRIEF.md
# Parallel flash command sequencer

This block is a clocked model of the control side of a byte-wide parallel flash. The bus master drives the three active-low strobes (chip enable, output enable, write enable), an address and a bidirectional byte lane. It may also raise a high-voltage flag on the identification line. The block first brings the strobes into the system clock domain. It then turns each completed bus write into one address/data event and feeds those events to a command state machine. That state machine recognises the unlock sequences for byte programming and sector erasing.

Accepted operations update a small storage array. Programming can only clear bits. Erasing walks one whole sector back to all-ones. A boot region of `BOOT_SECT` sectors sits either at the top or at the bottom of the address space, chosen at elaboration time, and a lock input can shield it. While an operation runs, `busy` is high, further writes are dropped and every read returns a fixed status byte. In all other cases the byte lane carries array data or an identification code, or floats.

The storage is scaled by parameters (`ADDR_W`, `SECT_AW`). The default is a 2 KB array of 64-byte sectors. Unlock addresses are the low `ADDR_W` bits of 5555h and 2AAAh.

Top module: `pflash_ctrl`

## Requirements
- R1: After reset `busy` is 0, the byte lane floats and the command state machine waits for a first unlock cycle.
- R2: With chip enable and output enable low and write enable high, the lane carries the stored byte at `addr` a few clocks later.
- R3: With chip enable high (whatever output enable does), or with output enable high, the lane floats.
- R4: A read drives the lane only if write enable was already high before chip enable and output enable both went low, and stayed high. Write enable low at any point of the read keeps the lane floating until chip enable or output enable returns high.
- R5: The program sequence is 555h/AAh, 2AAh/55h, 555h/A0h, then address/data. It sets the byte to old AND data, so bits are only ever cleared.
- R6: The erase sequence is 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, then any address in the sector with data 30h. It makes all bytes of that sector FFh and leaves every other sector unchanged.
- R7: A write that does not fit the expected next step (for example 555h/FFh) drops the partial sequence back to read mode. No program or erase follows from it.
- R8: An accepted program or erase holds `busy` at 1 for `BUSY_CYC` clocks. Any read in that window returns `BUSY_STAT` (default 3Ch).
- R9: Bus writes made while `busy` is 1 are ignored. They neither advance the state machine nor change the array.
- R10: With `a9_hv` high and addr bit 1 low, a read returns `MFR_ID` (default 40h) when addr bit 0 is 0 and `DEV_ID` (default D2h) when it is 1. With addr bit 1 high, a normal array read takes place.
- R11: With `TOP_BOOT`=1 the boot region is the highest `BOOT_SECT` sectors. While `boot_lock` is 1, a program or erase aimed there is rejected: `busy` stays 0 and the data stays unchanged. With `boot_lock` at 0 the operation is accepted, and sectors outside the region are never blocked.
- R12: A write may be controlled by either strobe. The address is taken when the later of chip enable and write enable falls, and the data when the earlier of them rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| dq | inout | 8 | Bidirectional data lane |
| a9_hv | input | 1 | High-voltage level on the identification line |
| boot_lock | input | 1 | Blocks program and erase in the boot region |
| busy | output | 1 | Program or erase in progress |

## Verification
The assertions assume that each strobe edge is at least three clocks away from the next one on any strobe. They also assume that the address and data are steady from before the later write-strobe fall until three clocks after the earlier rise, so that the synchronised view sees every bus cycle as the master meant it. The bench drives on falling clock edges and spaces every strobe change four clocks apart. It holds the address and the lane across each whole cycle. It changes them only where a check depends on which edge captures them.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

   typedef enum logic [2:0] {
      CS_READ,
      CS_UNL1,
      CS_UNL2,
      CS_PGM,
      CS_ESET,
      CS_EUN1,
      CS_EUN2
   } cmd_state_e;

   localparam logic [7:0] CD_UNL1 = 8'hAA;
   localparam logic [7:0] CD_UNL2 = 8'h55;
   localparam logic [7:0] CD_PGM  = 8'hA0;
   localparam logic [7:0] CD_ESET = 8'h80;
   localparam logic [7:0] CD_ERS  = 8'h30;

   localparam logic [15:0] UNL_ADDR1 = 16'h5555;
   localparam logic [15:0] UNL_ADDR2 = 16'h2AAA;

endpackage

// File: rtl/pflash_bus_if.sv
module pflash_bus_if #(
   parameter int ADDR_W = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        dq_in,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              rd_drive
);

   logic [SYNC_STAGES-1:0] ce_sy, oe_sy, we_sy;
   logic ce_s, oe_s, we_s;
   logic wr_on, wr_on_q, wr_ok, rd_arm;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ce_sy <= '1;
               oe_sy <= '1;
               we_sy <= '1;
            end else begin
               ce_sy <= ce_n;
               oe_sy <= oe_n;
               we_sy <= we_n;
            end
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ce_sy <= '1;
               oe_sy <= '1;
               we_sy <= '1;
            end else begin
               ce_sy <= {ce_sy[SYNC_STAGES-2:0], ce_n};
               oe_sy <= {oe_sy[SYNC_STAGES-2:0], oe_n};
               we_sy <= {we_sy[SYNC_STAGES-2:0], we_n};
            end
         end
      end
   endgenerate

   assign ce_s  = ce_sy[SYNC_STAGES-1];
   assign oe_s  = oe_sy[SYNC_STAGES-1];
   assign we_s  = we_sy[SYNC_STAGES-1];
   assign wr_on = !ce_s && !we_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_on_q  <= 1'b0;
         wr_ok    <= 1'b0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
         rd_arm   <= 1'b0;
      end else begin
         wr_on_q  <= wr_on;
         wr_valid <= 1'b0;
         if (wr_on && !wr_on_q) begin
            wr_addr <= addr;
            wr_ok   <= oe_s;
         end
         if (!wr_on && wr_on_q) begin
            wr_valid <= wr_ok;
            wr_data  <= dq_in;
         end
         if (ce_s || oe_s) begin
            rd_arm <= we_s;
         end else if (!we_s) begin
            rd_arm <= 1'b0;
         end
      end
   end

   assign rd_drive = !ce_s && !oe_s && we_s && rd_arm;

   AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid); // R12

   AST_RD_WE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_s && !ce_s && !oe_s) |=> !rd_drive); // R4

endmodule

// File: rtl/pflash_cmd_fsm.sv
module pflash_cmd_fsm
   import pflash_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              busy,
   output logic              pgm_req,
   output logic              ers_req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data
);

   localparam logic [ADDR_W-1:0] A_UNL1 = UNL_ADDR1[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_UNL2 = UNL_ADDR2[ADDR_W-1:0];

   cmd_state_e state;
   logic at_a1, is_u1, is_u2;

   assign at_a1 = (wr_addr == A_UNL1);
   assign is_u1 = at_a1 && (wr_data == CD_UNL1);
   assign is_u2 = (wr_addr == A_UNL2) && (wr_data == CD_UNL2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= CS_READ;
         pgm_req  <= 1'b0;
         ers_req  <= 1'b0;
         req_addr <= '0;
         req_data <= '0;
      end else begin
         pgm_req <= 1'b0;
         ers_req <= 1'b0;
         if (wr_valid && !busy) begin
            state <= CS_READ;
            case (state)
               CS_READ: if (is_u1) state <= CS_UNL1;
               CS_UNL1: if (is_u2) state <= CS_UNL2;
               CS_UNL2: begin
                  if (at_a1 && wr_data == CD_PGM)       state <= CS_PGM;
                  else if (at_a1 && wr_data == CD_ESET) state <= CS_ESET;
               end
               CS_PGM: begin
                  pgm_req  <= 1'b1;
                  req_addr <= wr_addr;
                  req_data <= wr_data;
               end
               CS_ESET: if (is_u1) state <= CS_EUN1;
               CS_EUN1: if (is_u2) state <= CS_EUN2;
               CS_EUN2: begin
                  if (wr_data == CD_ERS) begin
                     ers_req  <= 1'b1;
                     req_addr <= wr_addr;
                  end
               end
               default: state <= CS_READ;
            endcase
         end
      end
   end

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pgm_req, ers_req})); // R6

   AST_READ_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (pgm_req || ers_req) |-> (state == CS_READ)); // R7

endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
   parameter int          ADDR_W    = 11,
   parameter int          SECT_AW   = 6,
   parameter int          BOOT_SECT = 16,
   parameter bit          TOP_BOOT  = 1'b1,
   parameter int          BUSY_CYC  = 80,
   parameter logic [7:0]  BUSY_STAT = 8'h3C,
   parameter logic [7:0]  MFR_ID    = 8'h40,
   parameter logic [7:0]  DEV_ID    = 8'hD2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_req,
   input  logic              ers_req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   input  logic              boot_lock,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              a9_hv,
   output logic              busy,
   output logic [7:0]        rd_q
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int SECT_W = ADDR_W - SECT_AW;
   localparam int NSECT  = 1 << SECT_W;
   localparam int CNT_W  = $clog2(BUSY_CYC + 1);

   logic [7:0]         mem [DEPTH];
   logic [CNT_W-1:0]   busy_cnt;
   logic               erasing;
   logic [SECT_W-1:0]  ers_sect;
   logic [SECT_AW-1:0] ers_ptr;
   logic [SECT_W-1:0]  req_sect;
   logic               req_boot, accept;

   assign req_sect = req_addr[ADDR_W-1:SECT_AW];

   generate
      if (TOP_BOOT) begin : g_top_boot
         assign req_boot = (req_sect >= SECT_W'(NSECT - BOOT_SECT));
      end else begin : g_bot_boot
         assign req_boot = (req_sect < SECT_W'(BOOT_SECT));
      end
   endgenerate

   assign busy   = (busy_cnt != '0);
   assign accept = (pgm_req || ers_req) && !busy && !(boot_lock && req_boot);

   always_ff @(posedge clk) begin
      if (accept && pgm_req) begin
         mem[req_addr] <= mem[req_addr] & req_data;
      end
      if (erasing) begin
         mem[{ers_sect, ers_ptr}] <= 8'hFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         erasing  <= 1'b0;
         ers_sect <= '0;
         ers_ptr  <= '0;
         rd_q     <= '0;
      end else begin
         if (accept) begin
            busy_cnt <= CNT_W'(BUSY_CYC);
            erasing  <= ers_req;
            ers_sect <= req_sect;
            ers_ptr  <= '0;
         end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (erasing) begin
               ers_ptr <= ers_ptr + 1'b1;
               if (ers_ptr == '1) erasing <= 1'b0;
            end
         end
         if (busy)                      rd_q <= BUSY_STAT;
         else if (a9_hv && !rd_addr[1]) rd_q <= rd_addr[0] ? DEV_ID : MFR_ID;
         else                           rd_q <= mem[rd_addr];
      end
   end

   AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pgm_req || ers_req) && !busy && boot_lock && req_boot) |=> !busy); // R11

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      ((pgm_req || ers_req) && !busy && !(boot_lock && req_boot)) |=> busy); // R8

   AST_ERASE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      erasing |-> busy); // R6

   AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(pgm_req || ers_req)); // R9

endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl #(
   parameter int         ADDR_W      = 11,
   parameter int         SECT_AW     = 6,
   parameter int         BOOT_SECT   = 16,
   parameter bit         TOP_BOOT    = 1'b1,
   parameter int         BUSY_CYC    = 80,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] BUSY_STAT   = 8'h3C,
   parameter logic [7:0] MFR_ID      = 8'h40,
   parameter logic [7:0] DEV_ID      = 8'hD2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   inout  wire  [7:0]        dq,
   input  logic              a9_hv,
   input  logic              boot_lock,
   output logic              busy
);

   localparam int SECT_BYTES = 1 << SECT_AW;
   localparam int NSECT      = 1 << (ADDR_W - SECT_AW);

   generate
      if (ADDR_W < 11 || ADDR_W > 16) begin : g_bad_aw
         $error("pflash_ctrl: ADDR_W must lie in 11..16 so both unlock addresses differ");
      end
      if (SECT_AW < 1 || SECT_AW >= ADDR_W - 1) begin : g_bad_sect
         $error("pflash_ctrl: SECT_AW out of range");
      end
      if (BOOT_SECT < 1 || BOOT_SECT >= NSECT) begin : g_bad_boot
         $error("pflash_ctrl: BOOT_SECT must be below the sector count");
      end
      if (BUSY_CYC < SECT_BYTES) begin : g_bad_busy
         $error("pflash_ctrl: BUSY_CYC must cover the erase walk");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pflash_ctrl: SYNC_STAGES must be positive");
      end
   endgenerate

   logic [7:0]        dq_in, rd_q;
   logic              wr_valid, rd_drive, pgm_req, ers_req;
   logic [ADDR_W-1:0] wr_addr, req_addr;
   logic [7:0]        wr_data, req_data;

   assign dq_in = dq;
   assign dq    = rd_drive ? rd_q : 8'hzz;

   pflash_bus_if #(
      .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_drive(rd_drive)
   );

   pflash_cmd_fsm #(
      .ADDR_W(ADDR_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .pgm_req(pgm_req), .ers_req(ers_req),
      .req_addr(req_addr), .req_data(req_data)
   );

   pflash_array #(
      .ADDR_W(ADDR_W), .SECT_AW(SECT_AW), .BOOT_SECT(BOOT_SECT),
      .TOP_BOOT(TOP_BOOT), .BUSY_CYC(BUSY_CYC), .BUSY_STAT(BUSY_STAT),
      .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .ers_req(ers_req),
      .req_addr(req_addr), .req_data(req_data), .boot_lock(boot_lock),
      .rd_addr(addr), .a9_hv(a9_hv), .busy(busy), .rd_q(rd_q)
   );

endmodule

// File: tb/pflash_ctrl_tb.sv
module pflash_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 11;
   localparam int BUSY_N     = 400;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic          a9_hv = 1'b0, boot_lock = 1'b0;
   logic          busy;
   logic [7:0]    tb_dq = 8'h00;
   logic          tb_drv = 1'b0;
   wire  [7:0]    dq;
   int            n_vec = 0, n_bad = 0;

   assign dq = tb_drv ? tb_dq : 8'hzz;

   always #(CLK_PERIOD/2) clk = ~clk;

   pflash_ctrl #(.ADDR_W(AW), .BUSY_CYC(BUSY_N)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq(dq), .a9_hv(a9_hv), .boot_lock(boot_lock), .busy(busy)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
      addr = a; tb_dq = d; tb_drv = 1'b1; oe_n = 1'b1;
      tick(3); ce_n = 1'b0;
      tick(4); we_n = 1'b0;
      tick(4); we_n = 1'b1;
      tick(4); ce_n = 1'b1;
      tick(4); tb_drv = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] v);
      tb_drv = 1'b0; addr = a;
      tick(2); ce_n = 1'b0; oe_n = 1'b0;
      tick(6); v = dq;
      ce_n = 1'b1; oe_n = 1'b1;
      tick(4);
   endtask

   task automatic seq_pgm(input logic [AW-1:0] a, input logic [7:0] d);
      bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55);
      bus_wr(11'h555, 8'hA0); bus_wr(a, d);
   endtask

   task automatic seq_ers(input logic [AW-1:0] a);
      bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h80);
      bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(a, 8'h30);
   endtask

   task automatic wait_idle();
      tick(BUSY_N + 20);
   endtask

   task automatic t_reset();
      tick(3);
      chk("R1 busy after reset", {7'd0, busy}, 8'h00);
      chk("R1 lane floats after reset", dq, 8'hzz);
   endtask

   task automatic t_erase_basic();
      logic [7:0] v;
      seq_ers(11'h000);
      tick(2);
      chk("R8 busy after erase", {7'd0, busy}, 8'h01);
      bus_rd(11'h010, v);
      chk("R8 status read while busy", v, 8'h3C);
      wait_idle();
      chk("R8 busy cleared", {7'd0, busy}, 8'h00);
      seq_ers(11'h045);
      wait_idle();
      bus_rd(11'h000, v); chk("R6 sector0 first byte", v, 8'hFF);
      bus_rd(11'h03F, v); chk("R6 sector0 last byte", v, 8'hFF);
      bus_rd(11'h07F, v); chk("R6 sector1 last byte", v, 8'hFF);
   endtask

   task automatic t_program();
      logic [7:0] v;
      seq_pgm(11'h010, 8'h5A);
      tick(2);
      chk("R8 busy after program", {7'd0, busy}, 8'h01);
      wait_idle();
      bus_rd(11'h010, v); chk("R2/R5 program 5A", v, 8'h5A);
      seq_pgm(11'h010, 8'hF0);
      wait_idle();
      bus_rd(11'h010, v); chk("R5 AND semantics", v, 8'h50);
      seq_pgm(11'h050, 8'h12);
      wait_idle();
      bus_rd(11'h050, v); chk("R5 program sector1", v, 8'h12);
   endtask

   task automatic t_erase_isolation();
      logic [7:0] v;
      seq_ers(11'h020);
      tick(2);
      seq_pgm(11'h050, 8'h00);
      chk("R9 still busy during ignored writes", {7'd0, busy}, 8'h01);
      wait_idle();
      bus_rd(11'h010, v); chk("R6 erased byte back to FF", v, 8'hFF);
      bus_rd(11'h050, v); chk("R6/R9 other sector untouched", v, 8'h12);
   endtask

   task automatic t_abort();
      logic [7:0] v;
      bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55);
      bus_wr(11'h555, 8'hFF); bus_wr(11'h020, 8'h00);
      tick(2);
      chk("R7 no busy after abort", {7'd0, busy}, 8'h00);
      bus_rd(11'h020, v); chk("R7 no program after abort", v, 8'hFF);
      bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h80);
      bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h050, 8'h00);
      tick(2);
      chk("R7 bad erase command no busy", {7'd0, busy}, 8'h00);
      bus_rd(11'h050, v); chk("R7 bad erase command no erase", v, 8'h12);
   endtask

   task automatic t_ce_ctl();
      logic [7:0] v;
      bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'hA0);
      addr = 11'h031; tb_dq = 8'h3C; tb_drv = 1'b1; oe_n = 1'b1;
      tick(3); we_n = 1'b0;
      tick(4); addr = 11'h030; ce_n = 1'b0;
      tick(4); ce_n = 1'b1;
      tick(4); tb_dq = 8'hC3;
      tick(4); we_n = 1'b1;
      tick(4); tb_drv = 1'b0;
      wait_idle();
      bus_rd(11'h030, v); chk("R12 later fall gives addr, earlier rise gives data", v, 8'h3C);
      bus_rd(11'h031, v); chk("R12 earlier address not used", v, 8'hFF);
   endtask

   task automatic t_autoselect();
      logic [7:0] v;
      a9_hv = 1'b1;
      bus_rd(11'h000, v); chk("R10 manufacturer code", v, 8'h40);
      bus_rd(11'h001, v); chk("R10 device code", v, 8'hD2);
      bus_rd(11'h012, v); chk("R10 A1 high reads array", v, 8'hFF);
      a9_hv = 1'b0;
   endtask

   task automatic t_hiz();
      addr = 11'h050; tb_drv = 1'b0;
      ce_n = 1'b1; oe_n = 1'b0; tick(6);
      chk("R3 standby floats with OE low", dq, 8'hzz);
      ce_n = 1'b0; oe_n = 1'b1; tick(6);
      chk("R3 OE high floats", dq, 8'hzz);
      oe_n = 1'b0; tick(6);
      chk("R2 read drives", dq, 8'h12);
      oe_n = 1'b1; tick(6);
      chk("R3 OE rise ends read", dq, 8'hzz);
      ce_n = 1'b1; tick(4);
   endtask

   task automatic t_we_guard();
      addr = 11'h050; tb_drv = 1'b0;
      we_n = 1'b0; tick(4);
      ce_n = 1'b0; oe_n = 1'b0; tick(6);
      chk("R4 WE low no drive", dq, 8'hzz);
      we_n = 1'b1; tick(6);
      chk("R4 WE rise inside read no drive", dq, 8'hzz);
      ce_n = 1'b1; oe_n = 1'b1; tick(4);
      ce_n = 1'b0; oe_n = 1'b0; tick(6);
      chk("R4 clean read after guard", dq, 8'h12);
      we_n = 1'b0; tick(6);
      chk("R4 WE fall during read stops drive", dq, 8'hzz);
      ce_n = 1'b1; oe_n = 1'b1; tick(4); we_n = 1'b1; tick(4);
   endtask

   task automatic t_boot_lock();
      logic [7:0] v;
      boot_lock = 1'b0;
      seq_ers(11'h7C0);
      wait_idle();
      bus_rd(11'h7C5, v); chk("R11 unlocked boot erase", v, 8'hFF);
      boot_lock = 1'b1;
      seq_pgm(11'h7C5, 8'h00);
      tick(2);
      chk("R11 locked boot program rejected busy", {7'd0, busy}, 8'h00);
      bus_rd(11'h7C5, v); chk("R11 locked boot data kept", v, 8'hFF);
      seq_pgm(11'h020, 8'h77);
      wait_idle();
      bus_rd(11'h020, v); chk("R11 non-boot program while locked", v, 8'h77);
      boot_lock = 1'b0;
      seq_pgm(11'h7C5, 8'h0F);
      wait_idle();
      bus_rd(11'h7C5, v); chk("R11 boot program after unlock", v, 8'h0F);
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      t_reset();
      t_erase_basic();
      t_program();
      t_erase_isolation();
      t_abort();
      t_ce_ctl();
      t_autoselect();
      t_hiz();
      t_we_guard();
      t_boot_lock();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule